// File: doc/BRIEF.md
# Capture-Ordered Move Sequencer

This block hands out pseudo-legal chess moves one at a time. Each request returns the best move not yet handed out. It works from a 64-entry square array that holds one piece code per square, together with a reach matrix supplied by a neighbouring attack stage. The reach matrix says, for every pair of squares, whether the piece on one square can move to the other. The sequencer does not trace slides or jumps itself.

Selection runs in two stages. First, every square that the side to move could land on is scored in parallel, and a comparison tree picks the most valuable target. Opponent pieces score by kind; empty squares score zero, so every quiet move comes after every capture. Second, a tree picks the cheapest own piece that reaches that target. Attackers used for the current target are masked off one by one. When none are left, the target itself is masked, and later requests move on to the next target. A new-position strobe clears all masks.

A separate combinational query port tells whether a given from/to pair is a pseudo-legal move in the current position. A search can use it to validate a move recalled from its hash table.

Top module: `mvseq_top`

## Requirements
- R1: After reset `mv_valid` is low and no moves are masked. With no reach bits set, `done` is high.
- R2: A `req` pulse with moves remaining gives `mv_valid` high for exactly the following cycle, with `mv_from`/`mv_to` as 6-bit square indices. Without `req`, `mv_valid` stays low.
- R3: Once a non-capture has been emitted, no capture follows until the next `new_pos`.
- R4: Targets are taken in falling value order. The piece code is {colour, kind}: colour bit 3 (0 white, 1 black), and kind in bits 2:0 (0 empty, 1 pawn, 2 knight, 3 bishop, 4 rook, 5 queen, 6 king). An opponent target is valued at its kind, and an empty target at 0.
- R5: Among equally valued targets, the lower square index comes first.
- R6: For a fixed target, attackers come out in rising kind order, with ties going to the lower square index.
- R7: Each (from, to) pair is emitted once. All attackers of one target are emitted before the next target is begun.
- R8: Reach bit `to*64+from` counts only when the `from` square holds a piece of the side to move (`side` 0 white, 1 black) and the `to` square does not.
- R9: `done` is high once every move has been emitted. A `req` while `done` is high leaves `mv_valid` low.
- R10: `new_pos` clears all masks, takes priority over `req`, and restarts the order from the best move.
- R11: `q_ok` is high exactly when the `q_from`/`q_to` pair passes the R8 test in the current position, whether or not that move has already been emitted.
- R12: `mv_cap` is high exactly when the emitted target square held an opponent piece.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| board | input | 256 | Piece code of square s at bits [4s+3:4s] |
| side | input | 1 | Side to move, 0 white, 1 black |
| reach | input | 4096 | Bit to*64+from set when the piece on from can move to to |
| new_pos | input | 1 | Clears all masks for a new position |
| req | input | 1 | Request the next move |
| mv_valid | output | 1 | Move fields valid this cycle |
| mv_from | output | 6 | Origin square |
| mv_to | output | 6 | Destination square |
| mv_cap | output | 1 | Move is a capture |
| done | output | 1 | No moves remain |
| q_from | input | 6 | Query origin square |
| q_to | input | 6 | Query destination square |
| q_ok | output | 1 | Queried move is pseudo-legal now |

## Verification
The hardest situation to reach is the hand-over point inside one target's attacker list. The last attacker must mask the target and reset the attacker mask in the same cycle. A tie must also be settled by square index at both stages. The directed positions place two equal-valued targets with two equal-kind attackers each, plus a king as a third attacker on one target. Walking the full sequence then passes through each hand-over, and the order is checked move by move. Reach bits that start from enemy pieces or end on own pieces are mixed in, so that the filter of R8 is exercised inside the same sequence.

// File: rtl/mvseq_pkg.sv
package mvseq_pkg;
  localparam int PW = 4;

  typedef enum logic [2:0] {
    PK_NONE   = 3'd0,
    PK_PAWN   = 3'd1,
    PK_KNIGHT = 3'd2,
    PK_BISHOP = 3'd3,
    PK_ROOK   = 3'd4,
    PK_QUEEN  = 3'd5,
    PK_KING   = 3'd6
  } piece_kind_e;

  function automatic logic [2:0] kind_of(input logic [PW-1:0] code);
    return code[2:0];
  endfunction

  function automatic logic colour_of(input logic [PW-1:0] code);
    return code[3];
  endfunction
endpackage

// File: rtl/mvseq_pick.sv
// Comparison tree: picks the valid entry with the largest score, lower index on ties.
module mvseq_pick #(
  parameter int N  = 64,
  parameter int SW = 3,
  localparam int IW = $clog2(N),
  localparam int LV = $clog2(N)
) (
  input  logic [N-1:0]    ok,
  input  logic [N*SW-1:0] score,
  output logic            any,
  output logic [IW-1:0]   idx
);
  logic          v_a [LV+1][N];
  logic [IW-1:0] i_a [LV+1][N];
  logic [SW-1:0] s_a [LV+1][N];

  for (genvar n = 0; n < N; n++) begin : g_leaf
    assign v_a[0][n] = ok[n];
    assign i_a[0][n] = IW'(n);
    assign s_a[0][n] = score[n*SW +: SW];
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar n = 0; n < N; n++) begin : g_node
      if (n < (N >> (l+1))) begin : g_cmp
        logic take_r;
        assign take_r = v_a[l][2*n+1] &&
                        (!v_a[l][2*n] || (s_a[l][2*n+1] > s_a[l][2*n]));
        assign v_a[l+1][n] = v_a[l][2*n] | v_a[l][2*n+1];
        assign i_a[l+1][n] = take_r ? i_a[l][2*n+1] : i_a[l][2*n];
        assign s_a[l+1][n] = take_r ? s_a[l][2*n+1] : s_a[l][2*n];
      end else begin : g_pad
        assign v_a[l+1][n] = 1'b0;
        assign i_a[l+1][n] = '0;
        assign s_a[l+1][n] = '0;
      end
    end
  end

  assign any = v_a[LV][0];
  assign idx = i_a[LV][0];
endmodule

// File: rtl/mvseq_victims.sv
// Parallel target scan: ownership, eligibility and value of every square.
module mvseq_victims
  import mvseq_pkg::*;
#(
  parameter int NSQ = 64
) (
  input  logic [NSQ*PW-1:0]  board,
  input  logic               side,
  input  logic [NSQ*NSQ-1:0] reach,
  output logic [NSQ-1:0]     own_v,
  output logic [NSQ-1:0]     opp_v,
  output logic [NSQ-1:0]     elig,
  output logic [NSQ*3-1:0]   vscore
);
  for (genvar s = 0; s < NSQ; s++) begin : g_sq
    logic [PW-1:0] code;
    assign code     = board[s*PW +: PW];
    assign own_v[s] = (kind_of(code) != PK_NONE) && (colour_of(code) == side);
    assign opp_v[s] = (kind_of(code) != PK_NONE) && (colour_of(code) != side);
  end

  for (genvar t = 0; t < NSQ; t++) begin : g_tgt
    assign elig[t]          = !own_v[t] && |(reach[t*NSQ +: NSQ] & own_v);
    assign vscore[t*3 +: 3] = opp_v[t] ? kind_of(board[t*PW +: PW]) : 3'd0;
  end
endmodule

// File: rtl/mvseq_top.sv
module mvseq_top
  import mvseq_pkg::*;
#(
  parameter int NSQ = 64,
  localparam int SQW = $clog2(NSQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSQ*PW-1:0]  board,
  input  logic               side,
  input  logic [NSQ*NSQ-1:0] reach,
  input  logic               new_pos,
  input  logic               req,
  output logic               mv_valid,
  output logic [SQW-1:0]     mv_from,
  output logic [SQW-1:0]     mv_to,
  output logic               mv_cap,
  output logic               done,
  input  logic [SQW-1:0]     q_from,
  input  logic [SQW-1:0]     q_to,
  output logic               q_ok
);
  logic [NSQ-1:0]   own_v, opp_v, elig, vic_ok, att;
  logic [NSQ*3-1:0] vscore, ascore;
  logic             v_any, a_any, last;
  logic [SQW-1:0]   vt, af;

  logic [NSQ-1:0]   vmask_q, vmask_d, used_q, used_d;
  logic             valid_d, cap_d, upd;
  logic [SQW-1:0]   from_d, to_d;

  mvseq_victims #(.NSQ(NSQ)) u_vic (
    .board(board), .side(side), .reach(reach),
    .own_v(own_v), .opp_v(opp_v), .elig(elig), .vscore(vscore)
  );

  assign vic_ok = elig & ~vmask_q;

  mvseq_pick #(.N(NSQ), .SW(3)) u_vpick (
    .ok(vic_ok), .score(vscore), .any(v_any), .idx(vt)
  );

  assign att = reach[vt*NSQ +: NSQ] & own_v & ~used_q;

  for (genvar f = 0; f < NSQ; f++) begin : g_asc
    assign ascore[f*3 +: 3] = 3'd7 - kind_of(board[f*PW +: PW]);
  end

  mvseq_pick #(.N(NSQ), .SW(3)) u_apick (
    .ok(att), .score(ascore), .any(a_any), .idx(af)
  );

  assign last = ($countones(att) == 1);
  assign done = !v_any;
  assign q_ok = own_v[q_from] && !own_v[q_to] && reach[q_to*NSQ + q_from];
  assign upd  = new_pos | req | mv_valid;

  always_comb begin
    vmask_d = vmask_q;
    used_d  = used_q;
    valid_d = 1'b0;
    from_d  = mv_from;
    to_d    = mv_to;
    cap_d   = mv_cap;
    if (new_pos) begin
      vmask_d = '0;
      used_d  = '0;
    end else if (req && v_any) begin
      if (a_any) begin
        valid_d = 1'b1;
        from_d  = af;
        to_d    = vt;
        cap_d   = opp_v[vt];
      end
      if (!a_any || last) begin
        vmask_d[vt] = 1'b1;
        used_d      = '0;
      end else begin
        used_d[af]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmask_q  <= '0;
      used_q   <= '0;
      mv_valid <= 1'b0;
      mv_from  <= '0;
      mv_to    <= '0;
      mv_cap   <= 1'b0;
    end else if (upd) begin
      vmask_q  <= vmask_d;
      used_q   <= used_d;
      mv_valid <= valid_d;
      mv_from  <= from_d;
      mv_to    <= to_d;
      mv_cap   <= cap_d;
    end
  end

  // Assertion support: remembers that a quiet move has gone out.
  logic quiet_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   quiet_seen <= 1'b0;
    else if (new_pos)             quiet_seen <= 1'b0;
    else if (mv_valid && !mv_cap) quiet_seen <= 1'b1;
  end

  a_r2_no_req_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !mv_valid);
  a_r2_req_gives_move: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !new_pos && !done) |=> mv_valid);
  a_r3_quiet_last: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && quiet_seen) |-> !mv_cap);
  a_r9_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req && done) |=> !mv_valid);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    new_pos |=> (!mv_valid && vmask_q == '0));
  a_r7_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !new_pos |=> ((vmask_q & $past(vmask_q)) == $past(vmask_q)));
endmodule

// File: tb/tb_mvseq_top.sv
module tb_mvseq_top;
  logic          clk = 1'b0;
  logic          rst_n;
  logic [255:0]  board;
  logic          side;
  logic [4095:0] reach;
  logic          new_pos, req;
  logic          mv_valid, mv_cap, done, q_ok;
  logic [5:0]    mv_from, mv_to, q_from, q_to;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  mvseq_top dut (
    .clk(clk), .rst_n(rst_n), .board(board), .side(side), .reach(reach),
    .new_pos(new_pos), .req(req), .mv_valid(mv_valid), .mv_from(mv_from),
    .mv_to(mv_to), .mv_cap(mv_cap), .done(done), .q_from(q_from),
    .q_to(q_to), .q_ok(q_ok)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_pos(input logic s);
    board = '0;
    reach = '0;
    side  = s;
  endtask

  task automatic put(input int sq, input logic [3:0] code);
    board[sq*4 +: 4] = code;
  endtask

  task automatic link(input int from, input int to);
    reach[to*64 + from] = 1'b1;
  endtask

  task automatic strobe_new;
    @(negedge clk) new_pos = 1'b1;
    @(negedge clk) new_pos = 1'b0;
  endtask

  // One request; checks the move that appears the cycle after.
  task automatic ask(input string tag, input int v, input int f, input int t, input int c);
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    check({tag, " valid"}, int'(mv_valid), v);
    if (v != 0) begin
      check({tag, " from"}, int'(mv_from), f);
      check({tag, " to"},   int'(mv_to),   t);
      check({tag, " cap"},  int'(mv_cap),  c);
    end
  endtask

  task automatic query(input string tag, input int f, input int t, input int e);
    q_from = 6'(f);
    q_to   = 6'(t);
    #1;
    check(tag, int'(q_ok), e);
  endtask

  task automatic t_reset;
    check("R1 reset valid", int'(mv_valid), 0);
    check("R1 reset done",  int'(done), 1);
  endtask

  // Victim value order, attacker order, ownership filter, capture flag.
  task automatic t_order;
    clear_pos(1'b0);
    put(8, 4'h1); put(9, 4'h2); put(10, 4'h5);
    put(20, 4'hC); put(30, 4'hB);
    link(8, 20); link(10, 20); link(9, 30); link(10, 30);
    link(9, 40); link(10, 40);
    link(20, 8);   // enemy origin: ignored (R8)
    link(10, 9);   // own target: ignored (R8)
    strobe_new;
    check("R9 not done", int'(done), 0);
    query("R11 legal",       10, 20, 1);
    query("R11 enemy from",  20, 8,  0);
    query("R11 own target",  10, 9,  0);
    query("R11 no reach",    8,  30, 0);
    ask("R4 R6 rook by pawn",   1, 8,  20, 1);
    ask("R6 R7 rook by queen",  1, 10, 20, 1);
    ask("R4 bishop by knight",  1, 9,  30, 1);
    ask("R12 bishop by queen",  1, 10, 30, 1);
    ask("R3 quiet knight",      1, 9,  40, 0);
    ask("R8 quiet queen",       1, 10, 40, 0);
    check("R9 done", int'(done), 1);
    ask("R9 req when done", 0, 0, 0, 0);
    query("R11 after emit", 10, 20, 1);
    ask("R2 idle", 0, 0, 0, 0);
  endtask

  // Ties on victim value and attacker kind, king as last attacker.
  task automatic t_ties;
    clear_pos(1'b0);
    put(0, 4'h4); put(7, 4'h4); put(60, 4'h6);
    put(45, 4'hA); put(50, 4'hA);
    link(0, 45); link(7, 45); link(0, 50); link(7, 50); link(60, 50);
    link(0, 3); link(0, 2);
    strobe_new;
    ask("R5 tie low victim",      1, 0,  45, 1);
    ask("R6 tie low attacker",    1, 7,  45, 1);
    ask("R7 next victim",         1, 0,  50, 1);
    ask("R6 second rook",         1, 7,  50, 1);
    ask("R6 king last",           1, 60, 50, 1);
    ask("R5 quiet low index",     1, 0,  2,  0);
    ask("R5 quiet next",          1, 0,  3,  0);
    check("R9 done ties", int'(done), 1);
  endtask

  // Black to move, restart by new_pos, priority over req.
  task automatic t_restart;
    clear_pos(1'b1);
    put(33, 4'h9); put(24, 4'h5); put(40, 4'h1);
    link(33, 24); link(40, 33);
    strobe_new;
    ask("R8 black capture", 1, 33, 24, 1);
    check("R9 black done", int'(done), 1);
    @(negedge clk) begin new_pos = 1'b1; req = 1'b1; end
    @(negedge clk) begin new_pos = 1'b0; req = 1'b0; end
    check("R10 new_pos beats req", int'(mv_valid), 0);
    check("R10 cleared", int'(done), 0);
    ask("R10 restart", 1, 33, 24, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; new_pos = 1'b0; req = 1'b0;
    q_from = '0; q_to = '0;
    clear_pos(1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_order;
    t_ties;
    t_restart;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule